// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaled Compare

This block is a watchdog timer behind a small 32-bit register window. A 31-bit counter advances by one on each cycle where the `tick` enable is high and either of the two enable bits in the configuration register is set. The counter is shifted right by a programmable amount to form a 16-bit scaled view. When that view reaches or passes a 16-bit compare value, the block sets a sticky pending bit, which drives `irq`. Depending on configuration, the same event can also clear the counter and send a one-cycle system reset request.

Every write that changes the configuration, counter, feed or compare register must be preceded by a write of a key value to the key register. That unlock lasts for one write only. A feed clears the counter only when its data matches a second magic value. Reads return data one cycle after `rd_en`, showing the state from before that clock edge.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the configuration register (0x00) reads 0, compare (0x20) reads 0x0000BEEF, the unlock flag reads 0, and `irq` and `rst_req` are low.
- R2: Writing the key value (parameter, default 0x0051F15E) to offset 0x1C sets the unlock flag, which reads back in bit 0 of 0x1C. Any other value written there leaves the flag unchanged.
- R3: While the flag is clear, writes to offsets 0x00, 0x08, 0x18 and 0x20 change nothing. Each accepted write to one of them clears the flag.
- R4: The counter (0x08) is 31 bits wide and bit 31 always reads 0. It advances by one per `tick` only while bit 12 or bit 13 of the configuration register is set. An unlocked write loads data bits 30:0.
- R5: Offset 0x10 reads the low 16 bits of the counter shifted right by configuration bits 3:0. Writes to 0x10 are ignored and do not consume the unlock flag.
- R6: An unlocked write of the feed value (parameter, default 0x0D09F00D) to 0x18 clears the counter. Any other data leaves the counter as it was but still consumes the flag. 0x18 reads 0.
- R7: An unlocked write to 0x20 keeps only data bits 15:0.
- R8: When the scaled count is greater than or equal to the compare value, the pending bit (configuration bit 28) is set on the next edge and `irq` follows it. The bit stays set until an unlocked configuration write with bit 28 = 0 at a time when no match is present.
- R9: With configuration bit 9 set, a match clears the counter on the next edge. This takes priority over a tick.
- R10: With configuration bit 8 set, the start of a match produces a `rst_req` pulse exactly one cycle long.
- R11: Reads of unmapped offsets return 0. Writes to them change nothing and do not consume the flag.
- R12: `rdata` is loaded on the edge where `rd_en` is high and shows the register state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Low-frequency count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, mirrors the pending bit |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes with stable `addr` and `wdata` during the strobe. They also assume that `tick` is a clean enable in the same clock domain. The bench drives every input just after the falling edge and raises each strobe for exactly one cycle. It asserts `tick` only inside dedicated tick bursts, with no bus access in between, so that counter values at each read are exact.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFF_CFG  = 'h00;
  localparam int OFF_CNT  = 'h08;
  localparam int OFF_SCL  = 'h10;
  localparam int OFF_FEED = 'h18;
  localparam int OFF_KEY  = 'h1C;
  localparam int OFF_CMP  = 'h20;

  localparam int BIT_RSTEN = 8;
  localparam int BIT_ZCMP  = 9;
  localparam int BIT_ENA   = 12;
  localparam int BIT_ENW   = 13;
  localparam int BIT_PEND  = 28;

  localparam int WORD_W = 32;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate import wdt_pkg::*; #(
  parameter int          ADDR_W  = 6,
  parameter logic [31:0] KEY_VAL = 32'h0051F15E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              unlocked,
  output logic              acc_cfg,
  output logic              acc_cnt,
  output logic              acc_feed,
  output logic              acc_cmp
);
  logic is_cfg, is_cnt, is_feed, is_cmp, is_key, wr_prot;

  always_comb begin
    is_cfg  = (addr == ADDR_W'(OFF_CFG));
    is_cnt  = (addr == ADDR_W'(OFF_CNT));
    is_feed = (addr == ADDR_W'(OFF_FEED));
    is_cmp  = (addr == ADDR_W'(OFF_CMP));
    is_key  = (addr == ADDR_W'(OFF_KEY));
    wr_prot = wr_en & (is_cfg | is_cnt | is_feed | is_cmp);
  end

  always_ff @(posedge clk) begin
    if (rst)
      unlocked <= 1'b0;
    else if (wr_en && is_key && (wdata == KEY_VAL))
      unlocked <= 1'b1;
    else if (wr_prot && unlocked)
      unlocked <= 1'b0;
  end

  always_comb begin
    acc_cfg  = wr_en & unlocked & is_cfg;
    acc_cnt  = wr_en & unlocked & is_cnt;
    acc_feed = wr_en & unlocked & is_feed;
    acc_cmp  = wr_en & unlocked & is_cmp;
  end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int          CNT_W    = 31,
  parameter int          CMP_W    = 16,
  parameter int          SCALE_W  = 4,
  parameter logic [31:0] FEED_VAL = 32'h0D09F00D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               enable,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   cmp,
  input  logic               zero_on_match,
  input  logic               ld_cnt,
  input  logic [CNT_W-1:0]   ld_val,
  input  logic               feed_wr,
  input  logic [31:0]        feed_data,
  output logic [CNT_W-1:0]   count,
  output logic [CMP_W-1:0]   scaled,
  output logic               match
);
  logic [CNT_W-1:0] shifted;
  logic             feed_ok;

  always_comb begin
    shifted = count >> scale;
    scaled  = shifted[CMP_W-1:0];
    match   = (scaled >= cmp);
    feed_ok = feed_wr && (feed_data == FEED_VAL);
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (ld_cnt)
      count <= ld_val;
    else if (feed_ok)
      count <= '0;
    else if (match && zero_on_match)
      count <= '0;
    else if (enable && tick)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs #(
  parameter int          CMP_W   = 16,
  parameter int          SCALE_W = 4,
  parameter logic [15:0] CMP_RST = 16'hBEEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_cfg,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               rsten_in,
  input  logic               zcmp_in,
  input  logic               ena_in,
  input  logic               enw_in,
  input  logic               pend_in,
  input  logic               acc_cmp,
  input  logic [CMP_W-1:0]   cmp_in,
  input  logic               match,
  output logic [SCALE_W-1:0] scale,
  output logic               rsten,
  output logic               zcmp,
  output logic               ena,
  output logic               enw,
  output logic               pend,
  output logic [CMP_W-1:0]   cmp,
  output logic               rst_req
);
  logic fire, fire_q;

  always_comb fire = match & rsten;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale <= '0;
      rsten <= 1'b0;
      zcmp  <= 1'b0;
      ena   <= 1'b0;
      enw   <= 1'b0;
    end else if (acc_cfg) begin
      scale <= scale_in;
      rsten <= rsten_in;
      zcmp  <= zcmp_in;
      ena   <= ena_in;
      enw   <= enw_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (match)
      pend <= 1'b1;
    else if (acc_cfg)
      pend <= pend_in;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cmp <= CMP_W'(CMP_RST);
    else if (acc_cmp)
      cmp <= cmp_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      fire_q  <= fire;
      rst_req <= fire & ~fire_q;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed import wdt_pkg::*; #(
  parameter int          ADDR_W   = 6,
  parameter int          CNT_W    = 31,
  parameter int          CMP_W    = 16,
  parameter int          SCALE_W  = 4,
  parameter logic [31:0] KEY_VAL  = 32'h0051F15E,
  parameter logic [31:0] FEED_VAL = 32'h0D09F00D,
  parameter logic [15:0] CMP_RST  = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              rst_req
);
  logic               unlocked, acc_cfg, acc_cnt, acc_feed, acc_cmp;
  logic [SCALE_W-1:0] scale;
  logic               rsten, zcmp, ena, enw, pend, match;
  logic [CMP_W-1:0]   cmp, scaled;
  logic [CNT_W-1:0]   count;
  logic [31:0]        cfg_word, rd_mux;

  wdt_key_gate #(.ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL)) u_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(unlocked), .acc_cfg(acc_cfg), .acc_cnt(acc_cnt),
    .acc_feed(acc_feed), .acc_cmp(acc_cmp)
  );

  wdt_ctrl_regs #(.CMP_W(CMP_W), .SCALE_W(SCALE_W), .CMP_RST(CMP_RST)) u_regs (
    .clk(clk), .rst(rst), .acc_cfg(acc_cfg),
    .scale_in(wdata[SCALE_W-1:0]), .rsten_in(wdata[BIT_RSTEN]),
    .zcmp_in(wdata[BIT_ZCMP]), .ena_in(wdata[BIT_ENA]),
    .enw_in(wdata[BIT_ENW]), .pend_in(wdata[BIT_PEND]),
    .acc_cmp(acc_cmp), .cmp_in(wdata[CMP_W-1:0]), .match(match),
    .scale(scale), .rsten(rsten), .zcmp(zcmp), .ena(ena), .enw(enw),
    .pend(pend), .cmp(cmp), .rst_req(rst_req)
  );

  wdt_count_core #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
                   .FEED_VAL(FEED_VAL)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .enable(ena | enw), .scale(scale),
    .cmp(cmp), .zero_on_match(zcmp), .ld_cnt(acc_cnt),
    .ld_val(wdata[CNT_W-1:0]), .feed_wr(acc_feed), .feed_data(wdata),
    .count(count), .scaled(scaled), .match(match)
  );

  always_comb begin
    cfg_word                = '0;
    cfg_word[SCALE_W-1:0]   = scale;
    cfg_word[BIT_RSTEN]     = rsten;
    cfg_word[BIT_ZCMP]      = zcmp;
    cfg_word[BIT_ENA]       = ena;
    cfg_word[BIT_ENW]       = enw;
    cfg_word[BIT_PEND]      = pend;
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFF_CFG): rd_mux = cfg_word;
      ADDR_W'(OFF_CNT): rd_mux = 32'(count);
      ADDR_W'(OFF_SCL): rd_mux = 32'(scaled);
      ADDR_W'(OFF_KEY): rd_mux = 32'(unlocked);
      ADDR_W'(OFF_CMP): rd_mux = 32'(cmp);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  always_comb irq = pend;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int          ADDR_W  = 6,
  parameter int          CNT_W   = 31,
  parameter int          CMP_W   = 16,
  parameter logic [31:0] KEY_VAL = 32'h0051F15E
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              unlocked,
  input logic              enable,
  input logic              zcmp,
  input logic              match,
  input logic [CMP_W-1:0]  cmp,
  input logic [CNT_W-1:0]  count,
  input logic              irq,
  input logic              rst_req
);
  logic prot;
  always_comb prot = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h08)) ||
                     (addr == ADDR_W'('h18)) || (addr == ADDR_W'('h20));

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h1C) && wdata == KEY_VAL) |=> unlocked);

  // R3
  key_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unlocked && prot) |=> !unlocked);

  // R3
  locked_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && addr == ADDR_W'('h20)) |=> $stable(cmp));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_en && !match) |=> $stable(count));

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> irq);

  // R9
  zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (match && zcmp && !(wr_en && unlocked && addr == ADDR_W'('h08))) |=> (count == '0));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W),
                               .KEY_VAL(KEY_VAL)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .unlocked(unlocked), .enable(ena | enw), .zcmp(zcmp), .match(match),
  .cmp(cmp), .count(count), .irq(irq), .rst_req(rst_req)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
  localparam logic [31:0] KEY  = 32'h0051F15E;
  localparam logic [31:0] FEED = 32'h0D09F00D;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rst_req;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_keyed u_dut (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  // behavioural reference
  logic [31:0] m_cnt = 0, m_rdata = 0;
  logic [15:0] m_cmp = 16'hBEEF;
  logic [3:0]  m_scale = 0;
  bit m_rsten = 0, m_zc = 0, m_ena = 0, m_enw = 0, m_pend = 0, m_unl = 0;
  bit m_fire_q = 0, m_rreq = 0;

  always @(posedge clk) begin
    logic [31:0] scl, cfgw, nx_cnt;
    bit mt, prot, acc, fire;
    if (rst) begin
      m_cnt = 0; m_rdata = 0; m_cmp = 16'hBEEF; m_scale = 0;
      m_rsten = 0; m_zc = 0; m_ena = 0; m_enw = 0; m_pend = 0; m_unl = 0;
      m_fire_q = 0; m_rreq = 0;
    end else begin
      scl  = (m_cnt >> m_scale) & 32'hFFFF;
      mt   = (scl >= {16'h0, m_cmp});
      cfgw = {3'b0, m_pend, 14'b0, m_enw, m_ena, 2'b0, m_zc, m_rsten, 4'b0, m_scale};
      if (rd_en) begin
        case (addr)
          6'h00: m_rdata = cfgw;
          6'h08: m_rdata = m_cnt;
          6'h10: m_rdata = scl;
          6'h1C: m_rdata = {31'b0, m_unl};
          6'h20: m_rdata = {16'b0, m_cmp};
          default: m_rdata = 0;
        endcase
      end
      prot = wr_en && (addr == 6'h00 || addr == 6'h08 || addr == 6'h18 || addr == 6'h20);
      acc  = prot && m_unl;
      nx_cnt = m_cnt;
      if (acc && addr == 6'h08) nx_cnt = wdata & 32'h7FFFFFFF;
      else if (acc && addr == 6'h18 && wdata == FEED) nx_cnt = 0;
      else if (mt && m_zc) nx_cnt = 0;
      else if ((m_ena || m_enw) && tick) nx_cnt = (m_cnt + 1) & 32'h7FFFFFFF;
      fire = mt && m_rsten;
      m_rreq = fire && !m_fire_q;
      m_fire_q = fire;
      if (mt) m_pend = 1;
      else if (acc && addr == 6'h00) m_pend = wdata[28];
      if (acc && addr == 6'h00) begin
        m_scale = wdata[3:0]; m_rsten = wdata[8]; m_zc = wdata[9];
        m_ena = wdata[12]; m_enw = wdata[13];
      end
      if (acc && addr == 6'h20) m_cmp = wdata[15:0];
      if (wr_en && addr == 6'h1C && wdata == KEY) m_unl = 1;
      else if (acc) m_unl = 0;
      m_cnt = nx_cnt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the reference (R12, R8, R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R12 rdata vs model", rdata, m_rdata);
      chk("R8 irq vs model", {31'b0, irq}, {31'b0, m_pend});
      chk("R10 rst_req vs model", {31'b0, rst_req}, {31'b0, m_rreq});
      if (rst_req) pulses++;
    end
  end

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic unlock_wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr(6'h1C, KEY);
    bus_wr(a, d);
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 rst_req after reset", {31'b0, rst_req}, 0);
    bus_rd(6'h00, d); chk("R1 cfg reset", d, 0);
    bus_rd(6'h20, d); chk("R1 cmp reset", d, 32'h0000BEEF);
    bus_rd(6'h1C, d); chk("R1 key flag reset", d, 0);

    bus_wr(6'h20, 32'h1234);
    bus_rd(6'h20, d); chk("R3 locked cmp write ignored", d, 32'h0000BEEF);

    bus_wr(6'h1C, 32'h1);
    bus_rd(6'h1C, d); chk("R2 wrong key keeps flag clear", d, 0);
    bus_wr(6'h1C, KEY);
    bus_rd(6'h1C, d); chk("R2 key sets flag", d, 1);
    bus_wr(6'h20, 32'hABCD1234);
    bus_rd(6'h20, d); chk("R7 cmp low half kept", d, 32'h00001234);
    bus_rd(6'h1C, d); chk("R3 accepted write consumes flag", d, 0);

    unlock_wr(6'h20, 32'h0000FFFF);
    unlock_wr(6'h08, 32'h80000005);
    bus_rd(6'h08, d); chk("R4 counter bit31 dropped", d, 5);
    run_ticks(10);
    bus_rd(6'h08, d); chk("R4 disabled counter holds", d, 5);
    unlock_wr(6'h00, 32'h00001000);
    run_ticks(10);
    bus_rd(6'h08, d); chk("R4 enable-always counts", d, 15);
    bus_rd(6'h10, d); chk("R5 scaled shift 0", d, 15);
    unlock_wr(6'h00, 32'h00002002);
    run_ticks(5);
    bus_rd(6'h08, d); chk("R4 enable-awake counts", d, 20);
    bus_rd(6'h10, d); chk("R5 scaled shift 2", d, 5);

    unlock_wr(6'h10, 32'h99);
    bus_rd(6'h10, d); chk("R5 scaled write ignored", d, 5);
    bus_rd(6'h1C, d); chk("R5 scaled write keeps flag", d, 1);
    bus_wr(6'h18, 32'h1234);
    bus_rd(6'h08, d); chk("R6 wrong feed keeps counter", d, 20);
    bus_rd(6'h1C, d); chk("R6 wrong feed consumes flag", d, 0);
    bus_rd(6'h18, d); chk("R6 feed reads zero", d, 0);
    unlock_wr(6'h18, FEED);
    bus_rd(6'h08, d); chk("R6 magic feed clears counter", d, 0);

    unlock_wr(6'h20, 32'h3);
    run_ticks(12);
    repeat (2) @(negedge clk);
    chk("R8 irq on match", {31'b0, irq}, 1);
    bus_rd(6'h00, d); chk("R8 pending bit", d, 32'h10002002);
    unlock_wr(6'h08, 32'h0);
    chk("R8 pending sticky", {31'b0, irq}, 1);
    unlock_wr(6'h00, 32'h00002002);
    chk("R8 pending cleared by cfg write", {31'b0, irq}, 0);

    pulses = 0;
    unlock_wr(6'h00, 32'h00001300);
    run_ticks(8);
    repeat (2) @(negedge clk);
    chk("R10 one pulse per match", pulses, 2);
    bus_rd(6'h08, d); chk("R9 zero on match", d, 0);
    chk("R8 irq after rearm", {31'b0, irq}, 1);

    bus_wr(6'h1C, KEY);
    bus_wr(6'h04, 32'hFFFFFFFF);
    bus_rd(6'h1C, d); chk("R11 unmapped write keeps flag", d, 1);
    bus_rd(6'h04, d); chk("R11 unmapped read 0x04", d, 0);
    bus_rd(6'h3C, d); chk("R11 unmapped read 0x3C", d, 0);
    bus_rd(6'h20, d); chk("R11 cmp untouched", d, 3);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule